// File: doc/BRIEF.md
# Two-of-Seven Transition Link Endpoint

This block is both ends of an eight-wire chip-to-chip link. Seven wires carry symbols and one wire carries the acknowledge back. Signalling is by transition: a wire's level means nothing on its own, and only a change of level carries information. Every symbol toggles exactly two of the seven code wires. Sixteen of the twenty-one possible wire pairs carry a 4-bit value, and one more pair marks the end of a packet. The receiver answers each accepted symbol with a single toggle of the acknowledge wire. A symbol therefore costs one crossing of the link in each direction.

The transmitter takes bytes with a last marker through a valid/ready handshake. It sends each byte as two symbols, the low nibble first and then the high nibble. When the byte is the last one, an end-of-packet symbol follows. It sends no further symbol until it has seen the acknowledge change.

The receiver compares the incoming wires with a copy of the last state it accepted. A single changed wire is treated as a symbol still arriving. Two changed wires that form a used pair are decoded and acknowledged. Any other difference sets a sticky error flag and freezes the receiver. Received nibbles are put back together into bytes, and end-of-packet is reported as its own pulse. Both the incoming wires and the incoming acknowledge pass through a configurable synchronizer depth.

Top module: `link27_endpoint`

## Requirements
- R1: Wire k is bit k of the 7-bit wire vectors. The code pairs are listed in lexicographic order of (i,j) with i<j, so entry 0 is (0,1), entry 5 is (0,6), entry 6 is (1,2) and entry 10 is (1,6). Data value v uses entry v, and end-of-packet uses entry 16, which is wires (3,5).
- R2: Each symbol the transmitter sends toggles exactly two bits of tx_wire_o, and the wires hold their levels between symbols.
- R3: An accepted byte is sent as its low nibble and then its high nibble. When tx_last_i was set with the byte, an end-of-packet symbol follows the two nibbles.
- R4: tx_ready_o is high only when the transmitter is idle, and it drops on the cycle after a byte is accepted. No new symbol is sent until tx_ack_i has changed level since the previous symbol, so at most one symbol is ever outstanding.
- R5: The receiver accepts a symbol when exactly two wires differ from its last accepted state and they form one of the 17 used pairs. For each accepted symbol it toggles rx_ack_o exactly once.
- R6: A difference of a single wire is held as pending: no acknowledge, no error and no output until a second wire changes.
- R7: Two differing wires that form one of the unused pairs (3,6), (4,5), (4,6) or (5,6), or three or more differing wires, set rx_err_o. The flag stays set until reset, and after it is set no further symbol is acknowledged or accepted.
- R8: After a high nibble is accepted, rx_valid_o is high for one cycle with rx_data_o = {high, low}. An end-of-packet symbol raises rx_eop_o for one cycle. The two pulses never coincide.
- R9: An end-of-packet symbol that arrives while only a low nibble is held drops that half byte: no rx_valid_o is raised. The end-of-packet pulse is still given, and the next data symbol is taken as a low nibble.
- R10: With the link looped back, rx_valid_o for a byte is high in the cycle after the (3*SYNC_STAGES+4)th rising edge, counting the edge that accepted the byte as the first.
- R11: During and after reset, tx_wire_o and rx_ack_o are 0, tx_ready_o is 1, and rx_valid_o, rx_eop_o and rx_err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_data_i | input | 8 | Byte to send |
| tx_last_i | input | 1 | Byte ends its packet |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Transmitter idle; byte taken when valid is high |
| tx_wire_o | output | 7 | Outgoing code wires (transition coded) |
| tx_ack_i | input | 1 | Incoming acknowledge wire (toggle) |
| rx_wire_i | input | 7 | Incoming code wires (transition coded) |
| rx_ack_o | output | 1 | Outgoing acknowledge wire (toggle) |
| rx_data_o | output | 8 | Reassembled byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| rx_eop_o | output | 1 | One-cycle end-of-packet strobe |
| rx_err_o | output | 1 | Sticky illegal-code flag |

## Verification
The bench builds the block with SYNC_STAGES = 2. At that depth one symbol takes six cycles from wire toggle to seen acknowledge, and a byte reaches the receiver output ten edges after it is accepted. That is short enough for a loopback run to send every nibble value, isolated last bytes and multi-byte packets in a few hundred cycles. With the receive wires driven directly by the bench, the same build also reaches single-wire skew, a half byte cut short by end-of-packet, unused pairs and three-wire changes, along with the freeze that follows an error.

// File: rtl/link27_pkg.sv
`timescale 1ns/1ps
package link27_pkg;
  localparam int N_WIRES  = 7;
  localparam int NIB_W    = 4;
  localparam int BYTE_W   = 2 * NIB_W;
  localparam int N_DATA   = 1 << NIB_W;
  localparam int N_CODES  = N_DATA + 1;
  localparam int EOP_IDX  = N_DATA;
  localparam int IDX_W    = $clog2(N_CODES);

  typedef logic [N_WIRES-1:0] wires_t;
  typedef logic [NIB_W-1:0]   nib_t;
  typedef logic [IDX_W-1:0]   idx_t;

  typedef struct packed {
    logic hit;
    idx_t idx;
  } dec_t;

  typedef enum logic [1:0] {TX_IDLE, TX_LO, TX_HI, TX_EOP} tx_state_e;

  // entry n = n-th wire pair (i<j) in lexicographic order
  function automatic wires_t code_of(idx_t idx);
    wires_t c;
    int n;
    c = '0;
    n = 0;
    for (int i = 0; i < N_WIRES; i++) begin
      for (int j = i + 1; j < N_WIRES; j++) begin
        if (n == int'(idx)) begin
          c    = '0;
          c[i] = 1'b1;
          c[j] = 1'b1;
        end
        n++;
      end
    end
    return c;
  endfunction

  function automatic dec_t decode(wires_t d);
    dec_t r;
    r = '0;
    for (int k = 0; k < N_CODES; k++) begin
      if (d == code_of(idx_t'(k))) begin
        r.hit = 1'b1;
        r.idx = idx_t'(k);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/link27_sync.sv
`timescale 1ns/1ps
module link27_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign d_o = d_i;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int s = 0; s < int'(STAGES); s++) stg[s] <= '0;
        end else begin
          stg[0] <= d_i;
          for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
        end
      end
      assign d_o = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/link27_tx.sv
`timescale 1ns/1ps
module link27_tx
  import link27_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              last_i,
  input  logic              valid_i,
  output logic              ready_o,
  output wires_t            wire_o,
  input  logic              ack_i
);
  logic      ack_s;
  tx_state_e state_q, state_d;
  wires_t    wire_q, wire_d;
  logic      ack_q, ack_d;
  nib_t      hi_q, hi_d;
  logic      last_q, last_d;
  logic      ack_evt;

  link27_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .d_o   (ack_s)
  );

  assign ack_evt = ack_s ^ ack_q;

  always_comb begin
    state_d = state_q;
    wire_d  = wire_q;
    ack_d   = ack_q;
    hi_d    = hi_q;
    last_d  = last_q;
    unique case (state_q)
      TX_IDLE: if (valid_i) begin
        wire_d  = wire_q ^ code_of(idx_t'(data_i[NIB_W-1:0]));
        hi_d    = data_i[BYTE_W-1:NIB_W];
        last_d  = last_i;
        state_d = TX_LO;
      end
      TX_LO: if (ack_evt) begin
        ack_d   = ack_s;
        wire_d  = wire_q ^ code_of(idx_t'(hi_q));
        state_d = TX_HI;
      end
      TX_HI: if (ack_evt) begin
        ack_d = ack_s;
        if (last_q) begin
          wire_d  = wire_q ^ code_of(idx_t'(EOP_IDX));
          state_d = TX_EOP;
        end else begin
          state_d = TX_IDLE;
        end
      end
      TX_EOP: if (ack_evt) begin
        ack_d   = ack_s;
        state_d = TX_IDLE;
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      wire_q  <= '0;
      ack_q   <= 1'b0;
      hi_q    <= '0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wire_q  <= wire_d;
      ack_q   <= ack_d;
      hi_q    <= hi_d;
      last_q  <= last_d;
    end
  end

  assign ready_o = (state_q == TX_IDLE);
  assign wire_o  = wire_q;
endmodule

// File: rtl/link27_rx.sv
`timescale 1ns/1ps
module link27_rx
  import link27_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wires_t            wire_i,
  output logic              ack_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              eop_o,
  output logic              err_o
);
  wires_t wire_s, ref_q, diff;
  dec_t   dec;
  int     n_diff;
  logic   accept, bad;
  logic   ack_q, phase_q, err_q, valid_q, eop_q;
  nib_t   lo_q;
  logic [BYTE_W-1:0] data_q;

  link27_sync #(.W(N_WIRES), .STAGES(SYNC_STAGES)) u_wire_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wire_i),
    .d_o   (wire_s)
  );

  always_comb begin
    diff   = wire_s ^ ref_q;
    n_diff = $countones(diff);
    dec    = decode(diff);
    accept = !err_q && (n_diff == 2) && dec.hit;
    bad    = !err_q && ((n_diff > 2) || ((n_diff == 2) && !dec.hit));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= '0;
      ack_q   <= 1'b0;
      phase_q <= 1'b0;
      lo_q    <= '0;
      err_q   <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      eop_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      eop_q   <= 1'b0;
      if (bad) err_q <= 1'b1;
      if (accept) begin
        ref_q <= wire_s;
        ack_q <= ~ack_q;
        if (dec.idx == idx_t'(EOP_IDX)) begin
          eop_q   <= 1'b1;
          phase_q <= 1'b0;   // half byte dropped
        end else if (!phase_q) begin
          lo_q    <= dec.idx[NIB_W-1:0];
          phase_q <= 1'b1;
        end else begin
          data_q  <= {dec.idx[NIB_W-1:0], lo_q};
          valid_q <= 1'b1;
          phase_q <= 1'b0;
        end
      end
    end
  end

  assign ack_o   = ack_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign eop_o   = eop_q;
  assign err_o   = err_q;
endmodule

// File: rtl/link27_endpoint.sv
`timescale 1ns/1ps
module link27_endpoint
  import link27_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_last_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [N_WIRES-1:0] tx_wire_o,
  input  logic              tx_ack_i,
  input  logic [N_WIRES-1:0] rx_wire_i,
  output logic              rx_ack_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_eop_o,
  output logic              rx_err_o
);
  link27_tx #(.SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (tx_data_i),
    .last_i (tx_last_i),
    .valid_i(tx_valid_i),
    .ready_o(tx_ready_o),
    .wire_o (tx_wire_o),
    .ack_i  (tx_ack_i)
  );

  link27_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wire_i (rx_wire_i),
    .ack_o  (rx_ack_o),
    .data_o (rx_data_o),
    .valid_o(rx_valid_o),
    .eop_o  (rx_eop_o),
    .err_o  (rx_err_o)
  );
endmodule

// File: rtl/link27_checker.sv
`timescale 1ns/1ps
module link27_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic [6:0] tx_wire_o,
  input logic       rx_ack_o,
  input logic       rx_valid_o,
  input logic       rx_eop_o,
  input logic       rx_err_o
);
  assert_tx_two_wires_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wire_o != $past(tx_wire_o)) |-> ($countones(tx_wire_o ^ $past(tx_wire_o)) == 2));

  assert_one_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o |=> rx_err_o);

  assert_no_ack_after_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o |=> $stable(rx_ack_o));

  assert_ack_needs_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ack_o != $past(rx_ack_o)) |-> !$past(rx_err_o));

  assert_strobes_apart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && rx_eop_o));
endmodule

bind link27_endpoint link27_checker u_chk (.*);

// File: tb/tb_link27_endpoint.sv
`timescale 1ns/1ps
module tb_link27_endpoint;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_last = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [6:0] tx_wire;
  logic       tx_ack;
  logic [6:0] rx_wire;
  logic       rx_ack;
  logic [7:0] rx_data;
  logic       rx_valid, rx_eop, rx_err;

  logic       inj_en = 1'b0;
  logic [6:0] inj_wire = '0;
  logic       mon_en = 1'b0;

  assign rx_wire = inj_en ? inj_wire : tx_wire;
  assign tx_ack  = inj_en ? 1'b0 : rx_ack;

  link27_endpoint #(.SYNC_STAGES(S)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_data_i(tx_data), .tx_last_i(tx_last), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_wire_o(tx_wire), .tx_ack_i(tx_ack),
    .rx_wire_i(rx_wire), .rx_ack_o(rx_ack),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_eop_o(rx_eop), .rx_err_o(rx_err)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int exp_sym[$];
  int exp_out[$];
  int acc_cyc[$];
  int n_txc = 0, n_ack = 0;
  int cnt_valid = 0, cnt_eop = 0, last_data = 0;
  logic [6:0] prev_tx = '0;
  logic       prev_ack = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // independent enumeration of wire pairs i<j
  function automatic int ref_mask(int idx);
    int n = 0;
    for (int a = 0; a < 7; a++)
      for (int b = a + 1; b < 7; b++) begin
        if (n == idx) return (1 << a) | (1 << b);
        n++;
      end
    return 0;
  endfunction

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rx_valid) begin cnt_valid++; last_data = int'(rx_data); end
    if (rx_eop) cnt_eop++;
    if (mon_en) begin
      if (tx_wire != prev_tx) begin
        n_txc++;
        chk("R2 wires toggled per symbol", $countones(tx_wire ^ prev_tx), 2);
        if (exp_sym.size() == 0) chk("R3 unexpected symbol", 1, 0);
        else chk("R1/R3 symbol pair", int'(tx_wire ^ prev_tx), ref_mask(exp_sym.pop_front()));
      end
      if (rx_ack != prev_ack) n_ack++;
      chk("R4 at most one outstanding symbol", ((n_txc - n_ack) >= 0 && (n_txc - n_ack) <= 1) ? 1 : 0, 1);
      if (rx_valid) begin
        if (exp_out.size() == 0) chk("R8 unexpected byte", 1, 0);
        else chk("R8 received byte", int'(rx_data), exp_out.pop_front());
        if (acc_cyc.size() != 0) chk("R10 byte latency", cyc - acc_cyc.pop_front(), 3*S + 4);
      end
      if (rx_eop) begin
        if (exp_out.size() == 0) chk("R8 unexpected eop", 1, 0);
        else chk("R8 eop marker", 256, exp_out.pop_front());
      end
      chk("R7 no error in clean traffic", int'(rx_err), 0);
    end
    prev_tx  = tx_wire;
    prev_ack = rx_ack;
  end

  task automatic apply_reset();
    rst_n = 1'b0;
    mon_en = 1'b0;
    repeat (3) @(negedge clk);
    exp_sym.delete(); exp_out.delete(); acc_cyc.delete();
    n_txc = 0; n_ack = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic last);
    while (!tx_ready) @(negedge clk);
    tx_data = b; tx_last = last; tx_valid = 1'b1;
    exp_sym.push_back(int'(b[3:0]));
    exp_sym.push_back(int'(b[7:4]));
    exp_out.push_back(int'(b));
    if (last) begin exp_sym.push_back(16); exp_out.push_back(256); end
    acc_cyc.push_back(cyc);
    @(negedge clk);
    tx_valid = 1'b0; tx_last = 1'b0;
    chk("R4 ready low after accept", int'(tx_ready), 0);
  endtask

  task automatic drain();
    int g = 0;
    while ((exp_out.size() != 0 || !tx_ready) && g < 5000) begin @(negedge clk); g++; end
    repeat (4) @(negedge clk);
    chk("R3 all symbols sent", exp_sym.size(), 0);
    chk("R8 all outputs seen", exp_out.size(), 0);
  endtask

  task automatic settle();
    repeat (S + 3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int v0, e0, a0;
    repeat (2) @(negedge clk);
    // R11 during reset
    chk("R11 tx_wire in reset", int'(tx_wire), 0);
    chk("R11 tx_ready in reset", int'(tx_ready), 1);
    apply_reset();
    chk("R11 tx_wire after reset", int'(tx_wire), 0);
    chk("R11 rx_ack after reset", int'(rx_ack), 0);
    chk("R11 tx_ready after reset", int'(tx_ready), 1);
    chk("R11 rx_valid after reset", int'(rx_valid), 0);
    chk("R11 rx_eop after reset", int'(rx_eop), 0);
    chk("R11 rx_err after reset", int'(rx_err), 0);

    // loopback traffic
    mon_en = 1'b1;
    send(8'h00, 1'b1);
    drain();
    for (int k = 0; k < 8; k++) send({4'(2*k + 1), 4'(2*k)}, k == 7);
    send(8'hA5, 1'b0);
    send(8'h3C, 1'b0);
    send(8'hFF, 1'b1);
    send(8'h5A, 1'b1);
    drain();
    chk("R5 acks match symbols", n_ack, n_txc);

    // direct wire injection
    apply_reset();
    inj_en = 1'b1; inj_wire = '0;
    settle();
    v0 = cnt_valid; e0 = cnt_eop;
    inj_wire = 7'b0000001;
    repeat (10) @(negedge clk);
    chk("R6 single wire no ack", int'(rx_ack), 0);
    chk("R6 single wire no error", int'(rx_err), 0);
    inj_wire = 7'b0000011;           // entry 0: low nibble 0
    settle();
    chk("R5 pair accepted ack", int'(rx_ack), 1);
    chk("R6 no output on low nibble", cnt_valid - v0, 0);
    inj_wire = inj_wire ^ 7'b0101000; // entry 16: end of packet
    settle();
    chk("R9 eop pulse", cnt_eop - e0, 1);
    chk("R9 half byte dropped", cnt_valid - v0, 0);
    chk("R5 eop acked", int'(rx_ack), 0);
    inj_wire = inj_wire ^ 7'b1000001; // entry 5: low nibble 5
    settle();
    inj_wire = inj_wire ^ 7'b1000010; // entry 10: high nibble 10
    settle();
    chk("R9 phase restart byte count", cnt_valid - v0, 1);
    chk("R9 phase restart byte value", last_data, 8'hA5);
    chk("R5 two more acks", int'(rx_ack), 0);
    a0 = int'(rx_ack);
    inj_wire = inj_wire ^ 7'b1001000; // unused pair (3,6)
    settle();
    chk("R7 unused pair error", int'(rx_err), 1);
    chk("R7 unused pair not acked", int'(rx_ack), a0);
    inj_wire = inj_wire ^ 7'b1001000 ^ 7'b0000011;
    repeat (10) @(negedge clk);
    chk("R7 frozen after error", int'(rx_ack), a0);
    chk("R7 error sticky", int'(rx_err), 1);

    inj_wire = '0;
    apply_reset();
    settle();
    chk("R11 error cleared by reset", int'(rx_err), 0);
    inj_wire = 7'b0000111;           // three wires
    settle();
    chk("R7 three wires error", int'(rx_err), 1);
    chk("R7 three wires not acked", int'(rx_ack), 0);

    inj_wire = '0;
    apply_reset();
    settle();
    inj_wire = 7'b0110000;           // unused pair (4,5)
    settle();
    chk("R7 pair 4,5 error", int'(rx_err), 1);
    chk("R7 pair 4,5 not acked", int'(rx_ack), 0);

    inj_wire = '0;
    apply_reset();
    inj_en = 1'b0;
    settle();
    mon_en = 1'b1;
    send(8'hC3, 1'b1);
    drain();
    finish_run();
  end
endmodule